// File: doc/BRIEF.md
# AES-128 Encryption Engine with MixColumns Whitening

This block encrypts one 128-bit block with AES-128. It reuses a single round datapath, one round per clock. An optional stand-alone MixColumns stage can sit on the data path: on the plaintext before the cipher, on the ciphertext after it, or at both points. A 2-bit mode input chooses the variant when an operation starts. In every variant that uses the extra stage, the 128-bit key also passes through MixColumns before key expansion. Round keys are derived on the fly, one per round.

A request is accepted when `start` is high and the engine is idle. The engine then raises `busy` and steps through a fixed sequence of named states. `ST_IDLE` goes to `ST_PREMIX` when mode bit 0 is set, and to `ST_ADDKEY` otherwise. `ST_PREMIX` goes to `ST_ADDKEY`. `ST_ADDKEY` goes to `ST_ROUND`. `ST_ROUND` repeats until the last round. After the last round it goes to `ST_POSTMIX` when mode bit 1 is set, and back to `ST_IDLE` otherwise. `ST_POSTMIX` returns to `ST_IDLE`.

When the engine returns to `ST_IDLE`, it registers the result and pulses `done` for one cycle. The engine is already idle in that cycle, so a new `start` can be taken at the same time as `done`.

Top module: `aes_mcw_core`

## Requirements
- R1: With mode 00, the result is standard AES-128. Key 000102030405060708090a0b0c0d0e0f with plaintext 00112233445566778899aabbccddeeff gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R2: With mode 01, the result is AES-128 of MixColumns(plaintext) under MixColumns(key). The state is column-major: the most significant byte is row 0, column 0, and bytes fill down each column. MixColumns multiplies each column by the circulant matrix with first row {02,03,01,01} over GF(2^8), reduced by 0x11B.
- R3: With mode 10, the result is MixColumns applied to AES-128 of the plaintext under MixColumns(key).
- R4: With mode 11, the result is MixColumns of AES-128 of MixColumns(plaintext) under MixColumns(key).
- R5: `busy` rises on the clock edge that accepts `start`. `done` rises exactly 11 + mode[0] + mode[1] clock edges after that edge, and `busy` falls on the same edge that raises `done`.
- R6: `done` is high for exactly one cycle, and `busy` is low during that cycle.
- R7: `result` changes only on the edge that raises `done`, and holds its value at all other times.
- R8: `start`, `mode`, `plaintext` and `key` are ignored while `busy` is high. `busy` rises only after a sampled `start`.
- R9: A `start` seen during the `done` cycle is accepted and begins a new operation.
- R10: While `rst_n` is low, `busy`, `done` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request; sampled only while idle |
| mode | input | 2 | 00 plain, 01 pre-mix, 10 post-mix, 11 both |
| plaintext | input | 128 | Input block, byte 0 in the MSBs |
| key | input | 128 | Secret key, byte 0 in the MSBs |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 128 | Output block, held between completions |

## Verification
Two events can land in the same cycle: completion of one operation (the `done` pulse and the result update) and acceptance of the next request. The bench provokes this by holding `start` high across back-to-back operations, so the second request is sampled in the `done` cycle of the first. A behavioural model predicts `busy`, `done` and `result` on every clock. It confirms that the new operation starts at once, that the earlier result stays in place until the next completion, and that the next `done` arrives at the latency the new mode calls for.

// File: rtl/aes_mcw_pkg.sv
package aes_mcw_pkg;
    localparam int BYTE_W  = 8;
    localparam int N_ROWS  = 4;
    localparam int N_COLS  = 4;
    localparam int N_BYTES = N_ROWS * N_COLS;
    localparam int BLK_W   = N_BYTES * BYTE_W;
    localparam int WORD_W  = N_ROWS * BYTE_W;
    localparam logic [BYTE_W-1:0] RED_POLY = 8'h1b;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BLK_W-1:0]  blk_t;

    typedef enum logic [1:0] {
        MODE_PLAIN = 2'b00,
        MODE_PRE   = 2'b01,
        MODE_POST  = 2'b10,
        MODE_BOTH  = 2'b11
    } wmode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREMIX,
        ST_ADDKEY,
        ST_ROUND,
        ST_POSTMIX
    } phase_e;

    // multiply by x in GF(2^8)
    function automatic byte_t xtime(byte_t a);
        return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? RED_POLY : '0);
    endfunction

    function automatic byte_t gf_mul(byte_t a, byte_t b);
        byte_t acc;
        byte_t p;
        acc = '0;
        p   = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ p;
            p = xtime(p);
        end
        return acc;
    endfunction

    // a^254 by square-and-multiply; 0 maps to 0
    function automatic byte_t gf_inv(byte_t a);
        byte_t sq;
        byte_t acc;
        sq  = a;
        acc = 8'h01;
        for (int i = 0; i < BYTE_W - 1; i++) begin
            sq  = gf_mul(sq, sq);
            acc = gf_mul(acc, sq);
        end
        return acc;
    endfunction

    function automatic byte_t sbox(byte_t a);
        byte_t b;
        b = gf_inv(a);
        return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
                 ^ {b[3:0], b[7:4]} ^ 8'h63;
    endfunction
endpackage

// File: rtl/aes_mcw_mixcols.sv
module aes_mcw_mixcols
    import aes_mcw_pkg::*;
(
    input  blk_t din,
    output blk_t dout
);
    for (genvar c = 0; c < N_COLS; c++) begin : g_col
        byte_t b [N_ROWS];
        for (genvar r = 0; r < N_ROWS; r++) begin : g_in
            assign b[r] = din[BLK_W-1-(c*N_ROWS+r)*BYTE_W -: BYTE_W];
        end
        // circulant rows {02,03,01,01} rotated per output row
        for (genvar r = 0; r < N_ROWS; r++) begin : g_out
            assign dout[BLK_W-1-(c*N_ROWS+r)*BYTE_W -: BYTE_W] =
                xtime(b[r]) ^ xtime(b[(r+1)%N_ROWS]) ^ b[(r+1)%N_ROWS]
                ^ b[(r+2)%N_ROWS] ^ b[(r+3)%N_ROWS];
        end
    end
endmodule

// File: rtl/aes_mcw_round.sv
module aes_mcw_round
    import aes_mcw_pkg::*;
(
    input  blk_t din,
    input  blk_t rkey,
    input  logic last,
    output blk_t dout
);
    blk_t subd;
    blk_t shfd;
    blk_t mixd;

    for (genvar i = 0; i < N_BYTES; i++) begin : g_sub
        assign subd[BLK_W-1-i*BYTE_W -: BYTE_W] = sbox(din[BLK_W-1-i*BYTE_W -: BYTE_W]);
    end

    // row r rotates left by r columns
    for (genvar c = 0; c < N_COLS; c++) begin : g_scol
        for (genvar r = 0; r < N_ROWS; r++) begin : g_srow
            assign shfd[BLK_W-1-(c*N_ROWS+r)*BYTE_W -: BYTE_W] =
                subd[BLK_W-1-(((c+r)%N_COLS)*N_ROWS+r)*BYTE_W -: BYTE_W];
        end
    end

    aes_mcw_mixcols u_mix (.din(shfd), .dout(mixd));

    assign dout = (last ? shfd : mixd) ^ rkey;
endmodule

// File: rtl/aes_mcw_keystep.sv
module aes_mcw_keystep
    import aes_mcw_pkg::*;
(
    input  blk_t  kin,
    input  byte_t rcon,
    output blk_t  kout
);
    word_t w  [N_COLS];
    word_t nw [N_COLS];
    word_t rotw;
    word_t subw;

    for (genvar c = 0; c < N_COLS; c++) begin : g_split
        assign w[c] = kin[BLK_W-1-c*WORD_W -: WORD_W];
    end

    assign rotw = {w[N_COLS-1][WORD_W-BYTE_W-1:0], w[N_COLS-1][WORD_W-1 -: BYTE_W]};

    for (genvar j = 0; j < N_ROWS; j++) begin : g_subw
        assign subw[WORD_W-1-j*BYTE_W -: BYTE_W] = sbox(rotw[WORD_W-1-j*BYTE_W -: BYTE_W]);
    end

    assign nw[0] = w[0] ^ subw ^ {rcon, {(WORD_W-BYTE_W){1'b0}}};
    for (genvar c = 1; c < N_COLS; c++) begin : g_chain
        assign nw[c] = w[c] ^ nw[c-1];
    end

    for (genvar c = 0; c < N_COLS; c++) begin : g_join
        assign kout[BLK_W-1-c*WORD_W -: WORD_W] = nw[c];
    end
endmodule

// File: rtl/aes_mcw_core.sv
module aes_mcw_core
    import aes_mcw_pkg::*;
#(
    parameter int N_ROUNDS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       mode,
    input  logic [BLK_W-1:0] plaintext,
    input  logic [BLK_W-1:0] key,
    output logic             busy,
    output logic             done,
    output logic [BLK_W-1:0] result
);
    localparam int RND_W = $clog2(N_ROUNDS + 1);
    localparam logic [RND_W-1:0] LAST_RND = RND_W'(N_ROUNDS);

    phase_e           st_q, st_d;
    blk_t             dat_q;
    blk_t             rk_q;
    byte_t            rcon_q;
    logic [RND_W-1:0] rnd_q;
    logic             post_q;

    blk_t key_mixed;
    blk_t dat_mixed;
    blk_t rnd_out;
    blk_t rk_next;
    logic last_rnd;

    assign last_rnd = (rnd_q == LAST_RND);

    aes_mcw_mixcols u_kmix (.din(key),   .dout(key_mixed));
    aes_mcw_mixcols u_dmix (.din(dat_q), .dout(dat_mixed));
    aes_mcw_keystep u_kstep (.kin(rk_q), .rcon(rcon_q), .kout(rk_next));
    aes_mcw_round   u_round (.din(dat_q), .rkey(rk_next), .last(last_rnd), .dout(rnd_out));

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (start) st_d = mode[0] ? ST_PREMIX : ST_ADDKEY;
            ST_PREMIX:  st_d = ST_ADDKEY;
            ST_ADDKEY:  st_d = ST_ROUND;
            ST_ROUND:   if (last_rnd) st_d = post_q ? ST_POSTMIX : ST_IDLE;
            ST_POSTMIX: st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat_q  <= '0;
            rk_q   <= '0;
            rcon_q <= '0;
            rnd_q  <= '0;
            post_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start) begin
                    dat_q  <= plaintext;
                    rk_q   <= (mode != MODE_PLAIN) ? key_mixed : key;
                    post_q <= mode[1];
                end
                ST_PREMIX: dat_q <= dat_mixed;
                ST_ADDKEY: begin
                    dat_q  <= dat_q ^ rk_q;
                    rnd_q  <= RND_W'(1);
                    rcon_q <= 8'h01;
                end
                ST_ROUND: begin
                    dat_q  <= rnd_out;
                    rk_q   <= rk_next;
                    rcon_q <= xtime(rcon_q);
                    rnd_q  <= rnd_q + 1'b1;
                end
                ST_POSTMIX: dat_q <= dat_mixed;
                default: ;
            endcase
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            if (st_q == ST_ROUND && last_rnd && !post_q) begin
                done   <= 1'b1;
                result <= rnd_out;
            end else if (st_q == ST_POSTMIX) begin
                done   <= 1'b1;
                result <= dat_mixed;
            end
        end
    end

    assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/aes_mcw_chk.sv
module aes_mcw_chk #(
    parameter int N_ROUNDS = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [1:0]   mode,
    input logic         busy,
    input logic         done,
    input logic [127:0] result
);
    logic [7:0] age;
    logic [1:0] op_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age     <= '0;
            op_mode <= '0;
        end else if (start && !busy) begin
            age     <= '0;
            op_mode <= mode;
        end else if (busy) begin
            age <= age + 8'd1;
        end
    end

    // R5
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (age == 8'(N_ROUNDS + 1 + int'(op_mode[0]) + int'(op_mode[1]))));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R8
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R8
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

bind aes_mcw_core aes_mcw_chk #(.N_ROUNDS(N_ROUNDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .busy(busy), .done(done), .result(result)
);

// File: tb/aes_mcw_core_bench.sv
module aes_mcw_core_bench;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic [1:0]   mode;
    logic [127:0] pt;
    logic [127:0] key;
    logic         busy;
    logic         done;
    logic [127:0] result;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    aes_mcw_core u_aes_mcw_core (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .plaintext(pt), .key(key), .busy(busy), .done(done), .result(result)
    );

    // ---------------- behavioural reference ----------------
    function automatic logic [7:0] bm(logic [7:0] a, logic [7:0] b);
        logic [15:0] prod;
        prod = '0;
        for (int i = 0; i < 8; i++) if (b[i]) prod = prod ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (prod[i]) prod = prod ^ (16'h11b << (i - 8));
        return prod[7:0];
    endfunction

    function automatic logic [7:0] binv(logic [7:0] a);
        if (a == 8'h00) return 8'h00;
        for (int x = 1; x < 256; x++) if (bm(a, 8'(x)) == 8'h01) return 8'(x);
        return 8'h00;
    endfunction

    function automatic logic [7:0] bsb(logic [7:0] a);
        logic [7:0] b, o, cst;
        b = binv(a);
        cst = 8'h63;
        for (int i = 0; i < 8; i++)
            o[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ cst[i];
        return o;
    endfunction

    function automatic logic [7:0] gb(logic [127:0] v, int r, int c);
        return v[127 - 8*(4*c + r) -: 8];
    endfunction

    function automatic logic [127:0] bmix(logic [127:0] v);
        logic [127:0] u;
        u = '0;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                u = {u[119:0], bm(8'h02, gb(v, r, c)) ^ bm(8'h03, gb(v, (r+1)%4, c))
                               ^ gb(v, (r+2)%4, c) ^ gb(v, (r+3)%4, c)};
        return u;
    endfunction

    function automatic logic [127:0] baes(logic [127:0] p, logic [127:0] k);
        logic [31:0]  w [44];
        logic [31:0]  t;
        logic [7:0]   rc;
        logic [127:0] s, u;
        rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = k[127 - 32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            t = w[i-1];
            if (i % 4 == 0) begin
                t = {t[23:0], t[31:24]};
                t = {bsb(t[31:24]), bsb(t[23:16]), bsb(t[15:8]), bsb(t[7:0])} ^ {rc, 24'h0};
                rc = bm(rc, 8'h02);
            end
            w[i] = w[i-4] ^ t;
        end
        s = p ^ {w[0], w[1], w[2], w[3]};
        for (int rd = 1; rd <= 10; rd++) begin
            u = '0;
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++)
                    u = {u[119:0], bsb(gb(s, r, (c + r) % 4))};
            s = (rd < 10) ? bmix(u) : u;
            s = s ^ {w[4*rd], w[4*rd+1], w[4*rd+2], w[4*rd+3]};
        end
        return s;
    endfunction

    function automatic logic [127:0] bref(logic [127:0] p, logic [127:0] k, logic [1:0] m);
        logic [127:0] kk, pp, cc;
        kk = (m != 2'b00) ? bmix(k) : k;
        pp = m[0] ? bmix(p) : p;
        cc = baes(pp, kk);
        return m[1] ? bmix(cc) : cc;
    endfunction

    // cycle model
    logic         m_busy = 1'b0;
    logic         m_done = 1'b0;
    logic [127:0] m_res  = '0;
    logic [127:0] m_pend = '0;
    logic [1:0]   m_mode = 2'b00;
    logic [1:0]   m_dmode = 2'b00;
    int           m_cnt  = 0;
    int           n_done = 0;
    logic         was_busy;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_done = 1'b0; m_res = '0; m_cnt = 0;
        end else begin
            was_busy = m_busy;
            m_done = 1'b0;
            if (m_busy) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_busy = 1'b0; m_done = 1'b1; m_res = m_pend; m_dmode = m_mode;
                    n_done = n_done + 1;
                end
            end
            if (!was_busy && start) begin
                m_pend = bref(pt, key, mode);
                m_cnt  = 11 + int'(mode[0]) + int'(mode[1]);
                m_busy = 1'b1;
                m_mode = mode;
            end
        end
    end

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string mtag(logic [1:0] m);
        case (m)
            2'b00: return "R1 plain result";
            2'b01: return "R2 pre-mix result";
            2'b10: return "R3 post-mix result";
            default: return "R4 both-mix result";
        endcase
    endfunction

    // every-cycle comparison
    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R10 busy in reset", 128'(busy), 128'd0);
            chk("R10 done in reset", 128'(done), 128'd0);
            chk("R10 result in reset", result, 128'd0);
        end else begin
            chk("R5 busy timing", 128'(busy), 128'(m_busy));
            chk("R6 done pulse", 128'(done), 128'(m_done));
            if (m_done) chk(mtag(m_dmode), result, m_res);
            else        chk("R7 result hold", result, m_res);
        end
    end

    task automatic run(logic [1:0] m, logic [127:0] p, logic [127:0] k);
        @(negedge clk);
        mode = m; pt = p; key = k; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 40 && !m_done; i++) @(negedge clk);
    endtask

    localparam logic [127:0] KAT_K = 128'h000102030405060708090a0b0c0d0e0f;
    localparam logic [127:0] KAT_P = 128'h00112233445566778899aabbccddeeff;

    initial begin
        rst_n = 1'b0; start = 1'b0; mode = 2'b00; pt = '0; key = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 known answer
        run(2'b00, KAT_P, KAT_K);
        chk("R1 known answer", result, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);

        // R2 R3 R4 on the same inputs and another pair
        run(2'b01, KAT_P, KAT_K);
        run(2'b10, KAT_P, KAT_K);
        run(2'b11, KAT_P, KAT_K);
        run(2'b01, {4{32'hdeadbeef}}, '1);
        run(2'b10, '0, '0);
        run(2'b11, '1, {16{8'h5a}});

        // R8: inputs and start toggled while busy
        @(negedge clk);
        mode = 2'b10; pt = 128'h0123456789abcdef0fedcba987654321; key = KAT_K; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            mode = 2'(i); pt = ~pt; key = {key[126:0], key[127]}; start = i[0];
        end
        start = 1'b0;
        for (int i = 0; i < 40 && !m_done; i++) @(negedge clk);

        // R9: start held high so the next request lands in the done cycle
        @(negedge clk);
        mode = 2'b11; pt = KAT_P; key = KAT_K; start = 1'b1;
        begin
            int target;
            target = n_done + 2;
            for (int i = 0; i < 80 && n_done < target; i++) @(negedge clk);
            mode = 2'b00;
            target = n_done + 1;
            for (int i = 0; i < 40 && n_done < target; i++) @(negedge clk);
        end
        start = 1'b0;
        for (int i = 0; i < 40 && m_busy; i++) @(negedge clk);

        // mixed sequence of modes and data
        for (int i = 0; i < 4; i++)
            run(2'(i), {4{32'(i * 32'h1357_9bdf)}}, {4{32'(i * 32'h0f1e_2d3c + 1)}});

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R5 actual=hung expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule